// File: doc/BRIEF.md
# Occupancy-Driven Queue Resize Controller

This block decides how many entries of a resizable queue should be active. The queue can run at four sizes: 8, 16, 24 or 32 entries, one increment of 8 at a time. The controller watches the queue's valid-entry count and a flag saying that dispatch stalled because the queue was full. From these two observations it asks for a new size through a one-cycle strobe. The queue logic owns the actual resize: draining entries and moving them are not done here.

Shrinking is slow and deliberate. A free-running timer takes a snapshot of the occupancy once per sample period. Those snapshots are summed over an interval of several samples, and the sum is shifted down to form the average. At the end of the interval the controller picks the smallest size that could have held that average. When the average is far below the current size, the controller can drop several increments in one step.

Growing is fast. A stall counter counts full-queue dispatch stalls. As soon as that count passes a threshold, the controller asks for one more increment at once, without waiting for the interval to finish.

Top module: `occ_resize_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `resize_stb` is 0 and `req_cfg` is 3. A size code k stands for 8*(k+1) active entries.
- R2: `occ_count` is captured only on every 4th clock edge after reset or after a clear. The average is the sum of 8 consecutive captures shifted right by 3, with the fraction truncated.
- R3: On the 32nd edge after reset or a clear, the target size is taken from the average avg. The target is 0 when avg is 0; otherwise it is (avg-1)/8, limited to 3. When the target is below `cur_cfg`, the controller requests it, even if that skips more than one size.
- R4: If the target from R3 is not below `cur_cfg`, no strobe is given and `req_cfg` keeps its value.
- R5: Stall cycles are counted whether or not they are consecutive. On the edge that sees the 6th stall since the last clear, the controller requests `cur_cfg`+1 in that same cycle.
- R6: When `cur_cfg` is 3, a stall trigger gives no strobe and `req_cfg` stays 3.
- R7: If a stall trigger and an interval end fall on the same edge, the grow request wins over the shrink.
- R8: The stall count, the sample timer, the sample count and the sum are all cleared at every interval end and at every stall trigger. The next interval therefore ends 32 edges after the trigger.
- R9: `resize_stb` is high for exactly one cycle, the cycle after the deciding edge, and `req_cfg` changes on that same edge. At all other times `req_cfg` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_count | input | 6 | Number of valid queue entries (0 to 32) |
| full_stall | input | 1 | Dispatch blocked this cycle by a full queue |
| cur_cfg | input | 2 | Size code the queue is running at |
| req_cfg | output | 2 | Requested size code |
| resize_stb | output | 1 | One-cycle pulse when `req_cfg` carries a new request |

## Verification
The assertions assume that `occ_count` never exceeds 32. They also assume that `cur_cfg` is a settled size code; any two-bit value is accepted, and the strobe check compares the request with `cur_cfg` as it was on the deciding edge. The stimulus holds `cur_cfg` constant through each scenario, does not feed `req_cfg` back into it, and drives occupancy only between 0 and 32. Each scenario starts from reset, so the edge on which each decision lands can be counted exactly.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    localparam int INC_LOG2    = 3;
    localparam int INC_ENTRIES = 1 << INC_LOG2;
    localparam int NUM_CFG     = 4;
    localparam int CFG_W       = $clog2(NUM_CFG);
    localparam int MAX_ENTRIES = NUM_CFG * INC_ENTRIES;
    localparam int OCC_W       = $clog2(MAX_ENTRIES + 1);

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [OCC_W-1:0] occ_t;

    localparam cfg_t CFG_MIN = '0;
    localparam cfg_t CFG_MAX = cfg_t'(NUM_CFG - 1);

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_GROW   = 2'd1,
        ACT_SHRINK = 2'd2
    } act_e;

    typedef struct packed {
        act_e act;
        cfg_t target;
    } decision_t;

    // Smallest size code whose capacity covers the given occupancy.
    function automatic cfg_t fit_cfg(occ_t avg);
        occ_t m;
        if (avg == '0) begin
            return CFG_MIN;
        end
        m = (avg - 1'b1) >> INC_LOG2;
        if (m > occ_t'(CFG_MAX)) begin
            return CFG_MAX;
        end
        return cfg_t'(m);
    endfunction

    // One increment larger, saturating at the largest size.
    function automatic cfg_t grow_cfg(cfg_t c);
        return (c == CFG_MAX) ? c : cfg_t'(c + 1'b1);
    endfunction

endpackage

// File: rtl/qrs_sampler.sv
module qrs_sampler
    import qrs_pkg::*;
#(
    parameter int SAMPLE_LOG2  = 2,
    parameter int SAMPLES_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  occ_t occ_i,
    output logic interval_end_o,
    output occ_t avg_o
);

    localparam int ACC_W = OCC_W + SAMPLES_LOG2;

    logic sample_tick;
    logic last_sample;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    generate
        if (SAMPLE_LOG2 > 0) begin : g_timer
            logic [SAMPLE_LOG2-1:0] cyc_q;
            assign sample_tick = (cyc_q == '1);
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    cyc_q <= '0;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
        end else begin : g_every
            assign sample_tick = 1'b1;
        end

        if (SAMPLES_LOG2 > 0) begin : g_scount
            logic [SAMPLES_LOG2-1:0] samp_q;
            assign last_sample = (samp_q == '1);
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    samp_q <= '0;
                end else if (sample_tick) begin
                    samp_q <= samp_q + 1'b1;
                end
            end
        end else begin : g_single
            assign last_sample = 1'b1;
        end
    endgenerate

    assign acc_sum        = acc_q + ACC_W'(occ_i);
    assign interval_end_o = sample_tick && last_sample;
    assign avg_o          = OCC_W'(acc_sum >> SAMPLES_LOG2);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
        end else if (sample_tick) begin
            acc_q <= last_sample ? '0 : acc_sum;
        end
    end

endmodule

// File: rtl/qrs_overflow.sv
module qrs_overflow #(
    parameter int OVF_THRESH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic stall_i,
    output logic trig_o
);

    localparam int CNT_W = (OVF_THRESH > 0) ? $clog2(OVF_THRESH + 1) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign trig_o = stall_i && (cnt_q == CNT_W'(OVF_THRESH));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (stall_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/qrs_decide.sv
module qrs_decide
    import qrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cur_i,
    input  occ_t avg_i,
    input  logic interval_end_i,
    input  logic trig_i,
    output cfg_t req_o,
    output logic stb_o
);

    cfg_t      grow_t;
    cfg_t      fit_t;
    decision_t dec;

    assign grow_t = grow_cfg(cur_i);
    assign fit_t  = fit_cfg(avg_i);

    always_comb begin
        dec.act    = ACT_HOLD;
        dec.target = cur_i;
        if (trig_i) begin
            if (grow_t != cur_i) begin
                dec.act    = ACT_GROW;
                dec.target = grow_t;
            end
        end else if (interval_end_i && (fit_t < cur_i)) begin
            dec.act    = ACT_SHRINK;
            dec.target = fit_t;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= CFG_MAX;
            stb_o <= 1'b0;
        end else begin
            stb_o <= (dec.act != ACT_HOLD);
            if (dec.act != ACT_HOLD) begin
                req_o <= dec.target;
            end
        end
    end

endmodule

// File: rtl/occ_resize_ctrl.sv
module occ_resize_ctrl
    import qrs_pkg::*;
#(
    parameter int SAMPLE_LOG2  = 2,
    parameter int SAMPLES_LOG2 = 3,
    parameter int OVF_THRESH   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ_count,
    input  logic             full_stall,
    input  logic [CFG_W-1:0] cur_cfg,
    output logic [CFG_W-1:0] req_cfg,
    output logic             resize_stb
);

    logic interval_end;
    logic ovf_trig;
    logic clr;
    occ_t avg_occ;

    // A stall trigger restarts the whole measurement window.
    assign clr = ovf_trig;

    qrs_sampler #(
        .SAMPLE_LOG2 (SAMPLE_LOG2),
        .SAMPLES_LOG2(SAMPLES_LOG2)
    ) u_smp (
        .clk           (clk),
        .rst           (rst),
        .clr_i         (clr),
        .occ_i         (occ_count),
        .interval_end_o(interval_end),
        .avg_o         (avg_occ)
    );

    qrs_overflow #(
        .OVF_THRESH(OVF_THRESH)
    ) u_ovf (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (interval_end || ovf_trig),
        .stall_i(full_stall),
        .trig_o (ovf_trig)
    );

    qrs_decide u_dec (
        .clk           (clk),
        .rst           (rst),
        .cur_i         (cur_cfg),
        .avg_i         (avg_occ),
        .interval_end_i(interval_end),
        .trig_i        (ovf_trig),
        .req_o         (req_cfg),
        .stb_o         (resize_stb)
    );

endmodule

// File: rtl/occ_resize_chk.sv
module occ_resize_chk
    import qrs_pkg::*;
#(
    parameter int SAMPLE_LOG2  = 2,
    parameter int SAMPLES_LOG2 = 3,
    parameter int OVF_THRESH   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [OCC_W-1:0] occ_count,
    input logic [CFG_W-1:0] cur_cfg,
    input logic [CFG_W-1:0] req_cfg,
    input logic             resize_stb,
    input logic             interval_end,
    input logic             ovf_trig,
    input logic [OCC_W-1:0] avg_occ
);

    localparam bit PULSE_ONLY = (OVF_THRESH > 0) && (SAMPLE_LOG2 + SAMPLES_LOG2 > 0);

    p_occ_range_r2: assert property (@(posedge clk) disable iff (rst)
        int'(occ_count) <= MAX_ENTRIES);

    p_shrink_at_interval_r3: assert property (@(posedge clk) disable iff (rst)
        (resize_stb && (req_cfg < $past(cur_cfg))) |-> ($past(interval_end) && !$past(ovf_trig)));

    p_shrink_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (resize_stb && (req_cfg < $past(cur_cfg)))
            |-> ((int'(req_cfg) + 1) * INC_ENTRIES >= int'($past(avg_occ))));

    p_no_idle_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        resize_stb |-> (req_cfg != $past(cur_cfg)));

    p_grow_one_step_r5: assert property (@(posedge clk) disable iff (rst)
        (resize_stb && (req_cfg > $past(cur_cfg)))
            |-> ($past(ovf_trig) && (int'(req_cfg) == int'($past(cur_cfg)) + 1)));

    p_grow_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf_trig && interval_end && (cur_cfg != CFG_MAX))
            |=> (resize_stb && (int'(req_cfg) == int'($past(cur_cfg)) + 1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !resize_stb |-> $stable(req_cfg));

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (PULSE_ONLY && resize_stb) |=> !resize_stb);

endmodule

bind occ_resize_ctrl occ_resize_chk #(
    .SAMPLE_LOG2 (SAMPLE_LOG2),
    .SAMPLES_LOG2(SAMPLES_LOG2),
    .OVF_THRESH  (OVF_THRESH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .occ_count   (occ_count),
    .cur_cfg     (cur_cfg),
    .req_cfg     (req_cfg),
    .resize_stb  (resize_stb),
    .interval_end(interval_end),
    .ovf_trig    (ovf_trig),
    .avg_occ     (avg_occ)
);

// File: tb/sim_occ_resize_ctrl.sv
`timescale 1ns/1ps
module sim_occ_resize_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] occ_count = '0;
    logic       full_stall = 1'b0;
    logic [1:0] cur_cfg = 2'd3;
    logic [1:0] req_cfg;
    logic       resize_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    occ_resize_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .occ_count (occ_count),
        .full_stall(full_stall),
        .cur_cfg   (cur_cfg),
        .req_cfg   (req_cfg),
        .resize_stb(resize_stb)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Leaves the bench on a negedge with reset just released; the next
    // rising edge is edge 1 of the scenario.
    task automatic do_reset(input logic [1:0] cfg, input logic [5:0] occ);
        @(negedge clk);
        rst        = 1'b1;
        full_stall = 1'b0;
        cur_cfg    = cfg;
        occ_count  = occ;
        step();
        step();
        rst = 1'b0;
    endtask

    // Runs n edges with stalls on edges sfrom..sto, expects strobes only on
    // edges sa and sb (0 = none), carrying ea and eb respectively.
    task automatic run(string tag, int n, int sfrom, int sto,
                       int sa, int ea, int sb, int eb);
        int extra = 0;
        for (int p = 1; p <= n; p++) begin
            full_stall = (p >= sfrom) && (p <= sto);
            step();
            if (p == sa) begin
                check({tag, " strobe"}, int'(resize_stb), 1);
                check({tag, " req"}, int'(req_cfg), ea);
            end else if (p == sb) begin
                check({tag, " second strobe"}, int'(resize_stb), 1);
                check({tag, " second req"}, int'(req_cfg), eb);
            end else if (resize_stb) begin
                extra++;
            end
        end
        full_stall = 1'b0;
        check({tag, " / R9 no other strobe"}, extra, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R1 strobe in reset", int'(resize_stb), 0);
        check("R1 req in reset", int'(req_cfg), 3);
        do_reset(2'd3, 6'd0);
        check("R1 strobe after reset", int'(resize_stb), 0);
        check("R1 req after reset", int'(req_cfg), 3);
    endtask

    task automatic t_shrink_far();
        do_reset(2'd3, 6'd5);
        run("R3 avg 5 from size 3", 34, 0, -1, 32, 0, 0, 0);
    endtask

    task automatic t_shrink_partial();
        do_reset(2'd3, 6'd20);
        run("R3 avg 20 from size 3", 34, 0, -1, 32, 2, 0, 0);
    endtask

    task automatic t_boundary();
        do_reset(2'd1, 6'd8);
        run("R3 avg 8 from size 1", 34, 0, -1, 32, 0, 0, 0);
        do_reset(2'd1, 6'd9);
        run("R4 avg 9 at size 1", 70, 0, -1, 0, 0, 0, 0);
        check("R4 req holds", int'(req_cfg), 3);
    endtask

    task automatic t_full();
        do_reset(2'd3, 6'd32);
        run("R4 full at size 3", 70, 0, -1, 0, 0, 0, 0);
        check("R4 req stays", int'(req_cfg), 3);
    endtask

    // Captures on every 4th edge alternate 16 and 1 (sum 68, avg 8 after
    // truncation); all other edges carry 32.
    task automatic t_average();
        int seen = 0;
        do_reset(2'd3, 6'd32);
        for (int p = 1; p <= 33; p++) begin
            if ((p % 4) == 0) occ_count = ((p / 4) % 2 == 1) ? 6'd16 : 6'd1;
            else              occ_count = 6'd32;
            step();
            if (p == 32) begin
                check("R2 avg strobe", int'(resize_stb), 1);
                check("R2 truncated avg gives size 0", int'(req_cfg), 0);
            end else if (resize_stb) begin
                seen++;
            end
        end
        check("R2 no early strobe", seen, 0);
    endtask

    task automatic t_overflow();
        do_reset(2'd1, 6'd16);
        run("R5 six straight stalls", 7, 1, 7, 6, 2, 0, 0);
        do_reset(2'd1, 6'd16);
        begin
            int seen = 0;
            for (int p = 1; p <= 12; p++) begin
                full_stall = (p % 2) == 1;
                step();
                if (p == 11) begin
                    check("R5 sparse stall strobe", int'(resize_stb), 1);
                    check("R5 sparse stall req", int'(req_cfg), 2);
                end else if (resize_stb) begin
                    seen++;
                end
            end
            full_stall = 1'b0;
            check("R5 sparse no early strobe", seen, 0);
        end
    endtask

    task automatic t_clamp();
        do_reset(2'd3, 6'd32);
        run("R6 stall at size 3", 14, 1, 14, 0, 0, 0, 0);
        check("R6 req stays 3", int'(req_cfg), 3);
    endtask

    task automatic t_priority();
        do_reset(2'd2, 6'd0);
        run("R7 stall trigger on interval edge", 34, 27, 32, 32, 3, 0, 0);
    endtask

    task automatic t_clears();
        do_reset(2'd2, 6'd24);
        run("R8 stall count cleared at interval", 39, 28, 38, 38, 3, 0, 0);
        do_reset(2'd1, 6'd0);
        run("R8 sampler restarted by trigger", 40, 1, 6, 6, 2, 38, 0);
    endtask

    initial begin
        t_reset();
        t_shrink_far();
        t_shrink_partial();
        t_boundary();
        t_full();
        t_average();
        t_overflow();
        t_clamp();
        t_priority();
        t_clears();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule